// File: doc/BRIEF.md
# Command-Block Transmit Word DMA

This block moves a buffer of words from memory to a network transmitter, one word per transmitter wakeup. Software prepares a command block in memory and supplies its base address. The command block holds a start pointer, an end pointer, a post location for transfers and a post location for control commands. Each post location is followed by an interrupt-channel mask. There is no start register. While the internal output pointer is zero no transfer is in progress, and the next wakeup in that state loads both bounds from the command block and sends the first word.

Each later wakeup fetches one word, hands it to the transmitter and advances the pointer. The final word of the buffer carries a last-word flag. The wakeup after the final word sends nothing. On that wakeup the block writes a completion word to the post location, ORs the matching interrupt mask into a sticky pending register and returns the pointer to zero. A master-reset pulse abandons any transfer and posts to the control post location in the same way. The memory port has a fixed one-cycle read latency.

Top module: `cbtx_dma`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `tx_valid`, `tx_last`, `tx_ack`, `mem_rd` and `mem_wr` are low, `irq_pending` is zero and the output pointer is zero.
- R2: A wakeup while the output pointer is zero reads the start pointer at `cb_base+4` and the end pointer at `cb_base+5`. It then sends the word stored at the start pointer.
- R3: Each wakeup during a transfer sends the word at the current pointer on `tx_data`, with `tx_valid` and `tx_ack` high for exactly one cycle. The pointer then advances by one.
- R4: `tx_last` is high only together with `tx_valid`, and only for the word whose address is one below the end pointer.
- R5: The wakeup after the last word sends no data. It writes `0x1FF & hw_status` to `cb_base+10` and pulses `tx_ack`. The pointer returns to zero, so the following wakeup starts a new transfer as in R2.
- R6: Every completion post ORs the mask word that follows its post location into `irq_pending`. For a transfer the mask is at `cb_base+11`; for a control command it is at `cb_base+7`. Bits of `irq_pending` are cleared only by reset.
- R7: A `mreset` pulse writes `0x1FF & hw_status` to `cb_base+6`, abandons any transfer and zeroes the pointer. It does not pulse `tx_ack`.
- R8: If the loaded start pointer equals the end pointer, the first wakeup posts completion as in R5 and sends no word.
- R9: If a master reset and a wakeup are both waiting while the block is idle, the master reset is served first. The wakeup is then served as the start of a new transfer.
- R10: A `mreset` pulse that arrives while a word or post is being processed is held, and it is served as soon as that work finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cb_base | input | W | Base address of the command block |
| hw_status | input | W | Hardware status bits, ANDed into each posted word |
| mreset | input | 1 | Master-reset command pulse |
| tx_wake | input | 1 | Transmitter-ready wakeup, held until acknowledged |
| tx_ack | output | 1 | Wakeup consumed (word sent or transfer completion posted) |
| tx_valid | output | 1 | `tx_data` carries a word this cycle |
| tx_data | output | W | Word handed to the transmitter |
| tx_last | output | 1 | The word on `tx_data` is the final one of the buffer |
| mem_rd | output | 1 | Memory read request; data returns one cycle later |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | W | Memory word address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data from the previous cycle's request |
| irq_pending | output | W | Sticky OR of the interrupt masks of all posts |

## Verification
A master reset and a transmitter wakeup can both be waiting in the same idle cycle. They can also overlap when a reset pulse lands while a word fetch is in flight. The bench provokes the first case by raising `mreset` and `tx_wake` on the same edge. It provokes the second by pulsing `mreset` one cycle after a wakeup that continues a transfer. A behavioural model replays each case in the order R9 and R10 require, and every clock compares the sent words, the last-word flags and the posted memory writes against the queues the model filled.

// File: rtl/cbtx_pkg.sv
// Package: shared state encoding and command-block layout for the
// transmit word DMA. Offsets are word offsets from the command-block base.
package cbtx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LD_PTR,
        ST_LD_END,
        ST_LD_CHK,
        ST_FETCH,
        ST_SEND,
        ST_PST_WR,
        ST_PST_RD,
        ST_PST_OR
    } seq_state_e;

    localparam int unsigned OFS_OUT_PTR  = 4;
    localparam int unsigned OFS_OUT_END  = 5;
    localparam int unsigned OFS_CTL_POST = 6;
    localparam int unsigned OFS_OUT_POST = 10;

    localparam logic [8:0] DONE_CODE = 9'h1FF;

endpackage

// File: rtl/cbtx_ptrs.sv
// Module: cbtx_ptrs
// Holds the output pointer and the end pointer. It supplies the comparisons
// the sequencer branches on.
// Assumes: load, advance and clear strobes are mutually exclusive and come
// from the sequencer. mem_rdata is valid in the cycle a load strobe is high.
module cbtx_ptrs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mem_rdata,
    input  logic         ld_start,
    input  logic         ld_end,
    input  logic         advance,
    input  logic         clr,
    output logic [W-1:0] optr,
    output logic         ptr_zero,
    output logic         at_end,
    output logic         next_last,
    output logic         buf_empty
);

    logic [W-1:0] eptr;

    // Output pointer: load, step, or return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        optr <= '0;
        else if (clr)      optr <= '0;
        else if (ld_start) optr <= mem_rdata;
        else if (advance)  optr <= optr + W'(1);
    end

    // End pointer: captured once per transfer start.
    always_ff @(posedge clk) begin
        if (!rst_n)      eptr <= '0;
        else if (ld_end) eptr <= mem_rdata;
    end

    // Comparisons used by the sequencer.
    always_comb begin
        ptr_zero  = (optr == '0);
        at_end    = (optr == eptr);
        next_last = ((optr + W'(1)) == eptr);
        buf_empty = (mem_rdata == optr);
    end

    // A word is only sent while the pointer is inside the buffer.
    assert_send_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (!ptr_zero && !at_end));

    // The pointer steps by exactly one per sent word.
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (optr == $past(optr) + W'(1)));

endmodule

// File: rtl/cbtx_irq.sv
// Module: cbtx_irq
// Sticky interrupt-pending register. It accumulates the mask words read
// after each post.
// Assumes: or_en is high for one cycle, with the mask on mask_in.
module cbtx_irq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         or_en,
    input  logic [W-1:0] mask_in,
    output logic [W-1:0] irq_pending
);

    // Accumulate mask bits; only reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_pending <= '0;
        else if (or_en) irq_pending <= irq_pending | mask_in;
    end

    // Once set, a pending bit never falls outside reset.
    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pending & $past(irq_pending)) == $past(irq_pending)));

endmodule

// File: rtl/cbtx_seq.sv
// Module: cbtx_seq
// Control sequencer. In idle it picks between a held master reset and a
// transmitter wakeup. It then walks through initialisation, word send or
// completion post.
// Assumes: tx_wake stays high until tx_ack. Memory reads return data one
// cycle after mem_rd.
module cbtx_seq
    import cbtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_wake,
    input  logic       mreset,
    input  logic       ptr_zero,
    input  logic       at_end,
    input  logic       buf_empty,
    output seq_state_e state,
    output logic       post_is_ctl,
    output logic       ld_start,
    output logic       ld_end,
    output logic       advance,
    output logic       clr_ptr,
    output logic       or_en,
    output logic       tx_valid,
    output logic       tx_ack,
    output logic       mem_rd,
    output logic       mem_wr
);

    seq_state_e nxt;
    logic       pend_q, pend_n;
    logic       ctl_n;
    logic       rst_req;

    // A master reset is waiting if held from earlier or arriving now.
    assign rst_req = pend_q | mreset;

    // Next-state and post-kind selection.
    always_comb begin
        nxt   = state;
        ctl_n = post_is_ctl;
        unique case (state)
            ST_IDLE: begin
                if (rst_req) begin
                    nxt   = ST_PST_WR;
                    ctl_n = 1'b1;
                end else if (tx_wake) begin
                    if (ptr_zero) begin
                        nxt = ST_LD_PTR;
                    end else if (at_end) begin
                        nxt   = ST_PST_WR;
                        ctl_n = 1'b0;
                    end else begin
                        nxt = ST_FETCH;
                    end
                end
            end
            ST_LD_PTR: nxt = ST_LD_END;
            ST_LD_END: nxt = ST_LD_CHK;
            ST_LD_CHK: begin
                if (buf_empty) begin
                    nxt   = ST_PST_WR;
                    ctl_n = 1'b0;
                end else begin
                    nxt = ST_FETCH;
                end
            end
            ST_FETCH:  nxt = ST_SEND;
            ST_SEND:   nxt = ST_IDLE;
            ST_PST_WR: nxt = ST_PST_RD;
            ST_PST_RD: nxt = ST_PST_OR;
            ST_PST_OR: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Pending master reset: held until served from idle.
    always_comb begin
        pend_n = rst_req;
        if (state == ST_IDLE) pend_n = 1'b0;
    end

    // State, post kind and held-reset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            post_is_ctl <= 1'b0;
            pend_q      <= 1'b0;
        end else begin
            state       <= nxt;
            post_is_ctl <= ctl_n;
            pend_q      <= pend_n;
        end
    end

    // Strobes decoded from the current state.
    always_comb begin
        ld_start = (state == ST_LD_END);
        ld_end   = (state == ST_LD_CHK);
        advance  = (state == ST_SEND);
        clr_ptr  = (state == ST_PST_OR);
        or_en    = (state == ST_PST_OR);
        tx_valid = (state == ST_SEND);
        tx_ack   = (state == ST_SEND) || ((state == ST_PST_OR) && !post_is_ctl);
        mem_rd   = (state == ST_LD_PTR) || (state == ST_LD_END) ||
                   (state == ST_FETCH)  || (state == ST_PST_RD);
        mem_wr   = (state == ST_PST_WR);
    end

    // A reset waiting in idle beats a simultaneous wakeup.
    assert_reset_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rst_req && tx_wake) |=> (state == ST_PST_WR && post_is_ctl));

    // A reset pulse during busy work is not lost.
    assert_reset_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mreset && state != ST_IDLE) |=> pend_q);

    // Each acknowledge is a single-cycle pulse.
    assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |=> !tx_ack);

endmodule

// File: rtl/cbtx_dma.sv
// Module: cbtx_dma (top)
// Transmit word DMA driven by a command block in memory. It wires the
// sequencer, the pointer registers and the interrupt accumulator together,
// and it forms the memory address and post word.
// Assumes: W >= 9 so the completion code fits. Memory read latency is one cycle.
module cbtx_dma
    import cbtx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cb_base,
    input  logic [W-1:0] hw_status,
    input  logic         mreset,
    input  logic         tx_wake,
    output logic         tx_ack,
    output logic         tx_valid,
    output logic [W-1:0] tx_data,
    output logic         tx_last,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] irq_pending
);

    localparam logic [W-1:0] DONE_W = W'(DONE_CODE);

    seq_state_e   state;
    logic         post_is_ctl;
    logic         ld_start, ld_end, advance, clr_ptr, or_en;
    logic         ptr_zero, at_end, next_last, buf_empty;
    logic [W-1:0] optr;
    logic [W-1:0] post_ofs;

    cbtx_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_wake     (tx_wake),
        .mreset      (mreset),
        .ptr_zero    (ptr_zero),
        .at_end      (at_end),
        .buf_empty   (buf_empty),
        .state       (state),
        .post_is_ctl (post_is_ctl),
        .ld_start    (ld_start),
        .ld_end      (ld_end),
        .advance     (advance),
        .clr_ptr     (clr_ptr),
        .or_en       (or_en),
        .tx_valid    (tx_valid),
        .tx_ack      (tx_ack),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr)
    );

    cbtx_ptrs #(.W(W)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rdata (mem_rdata),
        .ld_start  (ld_start),
        .ld_end    (ld_end),
        .advance   (advance),
        .clr       (clr_ptr),
        .optr      (optr),
        .ptr_zero  (ptr_zero),
        .at_end    (at_end),
        .next_last (next_last),
        .buf_empty (buf_empty)
    );

    cbtx_irq #(.W(W)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .or_en       (or_en),
        .mask_in     (mem_rdata),
        .irq_pending (irq_pending)
    );

    // Post location offset for the post under way.
    assign post_ofs = post_is_ctl ? W'(OFS_CTL_POST) : W'(OFS_OUT_POST);

    // Memory address for each state that touches memory.
    always_comb begin
        unique case (state)
            ST_LD_PTR: mem_addr = cb_base + W'(OFS_OUT_PTR);
            ST_LD_END: mem_addr = cb_base + W'(OFS_OUT_END);
            ST_FETCH:  mem_addr = optr;
            ST_PST_WR: mem_addr = cb_base + post_ofs;
            ST_PST_RD: mem_addr = cb_base + post_ofs + W'(1);
            default:   mem_addr = '0;
        endcase
    end

    // Posted word and transmitter outputs.
    always_comb begin
        mem_wdata = mem_wr ? (DONE_W & hw_status) : '0;
        tx_data   = tx_valid ? mem_rdata : '0;
        tx_last   = tx_valid && next_last;
    end

    // The last-word flag never appears without a word.
    assert_last_with_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // Reads and writes are never issued together.
    assert_one_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // A completion post never coincides with a word on the transmitter.
    assert_post_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !tx_valid);

endmodule

// File: tb/sim_cbtx_dma.sv
`timescale 1ns/1ps
// Bench: a behavioural model fills queues of expected words and posts.
// Every clock the outputs are compared against those queues.
module sim_cbtx_dma;

    localparam int W  = 16;
    localparam int CB = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cb_base = W'(CB);
    logic [W-1:0] hw_status = 16'hFFFF;
    logic         mreset = 1'b0;
    logic         tx_wake = 1'b0;
    logic         tx_ack, tx_valid, tx_last, mem_rd, mem_wr;
    logic [W-1:0] tx_data, mem_addr, mem_wdata, irq_pending;
    logic [W-1:0] mem_rdata = '0;
    logic [W-1:0] mem [0:255];

    int vectors = 0;
    int fails   = 0;

    // Model state and expectation queues.
    int    m_ptr = 0, m_end = 0;
    int    m_irq = 0;
    int    q_d[$];
    bit    q_l[$];
    string q_t[$];
    int    w_a[$], w_d[$];
    string w_t[$];

    always #2 clk = ~clk;

    cbtx_dma #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cb_base(cb_base), .hw_status(hw_status),
        .mreset(mreset), .tx_wake(tx_wake), .tx_ack(tx_ack), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq_pending(irq_pending)
    );

    // Memory with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model of one wakeup.
    task automatic model_wake();
        string tag;
        tag = "R3";
        if (m_ptr == 0) begin
            m_ptr = int'(mem[CB+4]);
            m_end = int'(mem[CB+5]);
            tag = "R2";
            if (m_ptr == m_end) begin
                w_a.push_back(CB+10); w_d.push_back(int'(16'h01FF & hw_status));
                w_t.push_back("R8");
                m_irq |= int'(mem[CB+11]);
                m_ptr = 0;
                return;
            end
        end
        if (m_ptr == m_end) begin
            w_a.push_back(CB+10); w_d.push_back(int'(16'h01FF & hw_status));
            w_t.push_back("R5");
            m_irq |= int'(mem[CB+11]);
            m_ptr = 0;
        end else begin
            q_d.push_back(int'(mem[m_ptr[7:0]]));
            q_l.push_back(m_ptr + 1 == m_end);
            q_t.push_back((m_ptr + 1 == m_end) ? {tag, "/R4"} : tag);
            m_ptr++;
        end
    endtask

    // Model of one master reset.
    task automatic model_mreset();
        w_a.push_back(CB+6); w_d.push_back(int'(16'h01FF & hw_status));
        w_t.push_back("R7");
        m_irq |= int'(mem[CB+7]);
        m_ptr = 0;
    endtask

    // Per-clock comparison against the model queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                if (q_d.size() == 0) begin
                    check(1'b0, "R3 unexpected word", int'(tx_data), 0);
                end else begin
                    check(int'(tx_data) == q_d[0] && tx_last == q_l[0],
                          q_t[0], int'({tx_last, tx_data}), int'({q_l[0], q_d[0][15:0]}));
                    void'(q_d.pop_front()); void'(q_l.pop_front()); void'(q_t.pop_front());
                end
            end else begin
                check(!tx_last, "R4 flag without word", int'(tx_last), 0);
            end
            if (mem_wr) begin
                if (w_a.size() == 0) begin
                    check(1'b0, "R5 unexpected post", int'(mem_addr), 0);
                end else begin
                    check(int'(mem_addr) == w_a[0] && int'(mem_wdata) == w_d[0],
                          w_t[0], int'({mem_addr, mem_wdata}), (w_a[0] << 16) | w_d[0]);
                    void'(w_a.pop_front()); void'(w_d.pop_front()); void'(w_t.pop_front());
                end
            end
        end
    end

    // Raise a wakeup and hold it until acknowledged.
    task automatic do_wake();
        model_wake();
        @(negedge clk); tx_wake = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_ack) break;
        end
        tx_wake = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic check_irq(input string tag);
        check(int'(irq_pending) == m_irq, tag, int'(irq_pending), m_irq);
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7 + 16'h1100);
        mem[CB+4]  = 16'h0040; mem[CB+5] = 16'h0043;
        mem[CB+7]  = 16'h0030; mem[CB+11] = 16'h0005;

        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held.
        check(!tx_valid && !tx_last && !tx_ack && !mem_rd && !mem_wr && irq_pending == 0,
              "R1 during reset", int'({tx_valid, tx_ack, mem_rd, mem_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_valid && !tx_ack && !mem_rd && !mem_wr && irq_pending == 0,
              "R1 after reset", int'({tx_valid, tx_ack, mem_rd, mem_wr}), 0);

        // R2, R3, R4: three-word transfer, then R5 completion and R6 mask.
        repeat (3) do_wake();
        do_wake();
        settle();
        check_irq("R6 output mask");

        // R5: pointer back at zero, so a new transfer reloads the bounds.
        mem[CB+4] = 16'h0050; mem[CB+5] = 16'h0052; mem[CB+11] = 16'h0100;
        hw_status = 16'h00F0;
        repeat (3) do_wake();
        settle();
        check_irq("R6 sticky accumulate");

        // R7: master reset in mid-transfer, control mask at +7.
        hw_status = 16'hFFFF;
        mem[CB+4] = 16'h0060; mem[CB+5] = 16'h0064;
        do_wake();
        model_mreset();
        @(negedge clk); mreset = 1'b1;
        @(negedge clk); mreset = 1'b0;
        settle();
        check_irq("R7 control mask");

        // R9: master reset and wakeup raised together.
        mem[CB+7] = 16'h0800;
        model_mreset();
        model_wake();
        @(negedge clk); mreset = 1'b1; tx_wake = 1'b1;
        @(negedge clk); mreset = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (tx_ack) break;
            @(negedge clk);
        end
        tx_wake = 1'b0;
        settle();
        check_irq("R9 reset then restart");

        // R10: reset pulse lands while a word fetch is in flight.
        mem[CB+7] = 16'h2000;
        model_wake();
        model_mreset();
        @(negedge clk); tx_wake = 1'b1;
        @(negedge clk); mreset = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            mreset = 1'b0;
            if (tx_ack) break;
        end
        tx_wake = 1'b0;
        settle();
        check_irq("R10 held reset");

        // R8: zero-length buffer posts at once.
        mem[CB+4] = 16'h0070; mem[CB+5] = 16'h0070; mem[CB+11] = 16'h4000;
        do_wake();
        settle();
        check_irq("R8 empty buffer mask");

        check(q_d.size() == 0, "R3 words outstanding", q_d.size(), 0);
        check(w_a.size() == 0, "R5 posts outstanding", w_a.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule